// File: doc/BRIEF.md
# External Interrupt Pin Mapper

This block takes the pins of several 16-pin ports and maps them onto sixteen external interrupt request lines. Each request first chooses a port and then one pin from the group of four pins that matches the request's own group. The chosen pins pass through a two-flop synchronizer before any of their levels are used. Several requests may choose the same physical pin.

The synchronized level of each request goes out on an event output, whatever its interrupt enable is set to. Each request also has separate rising and falling edge enables. An enabled edge sets a sticky flag, and software clears the flag by writing a 1 to it. Enabled flags are merged into two interrupt lines, one for even request numbers and one for odd request numbers, behind a global sense enable. All configuration sits behind a simple write strobe and a combinational read port.

Top module: `extint_mapper`

## Requirements
- R1: After reset every flag is 0, both interrupt outputs are 0 and every configuration register reads back as 0.
- R2: Request n takes its port from a 4-bit field. Requests 0-7 use address 0x0, bits [4n+3:4n]. Requests 8-15 use address 0x1, bits [4(n-8)+3:4(n-8)]. Port k pin p is input bit 16k+p. A port value at or above NUM_PORTS gives a constant 0 level.
- R3: Request n takes pin 4*(n/4)+s, where s is the 2-bit field at address 0x2, bits [2n+1:2n]. With s=0 after reset, requests 0-3 all follow pin 0 of port 0.
- R4: One physical pin may be selected by several requests at once, and each of them follows it.
- R5: evt_o[n] follows the selected pin level two clock edges after the pin changes, independent of the interrupt enable.
- R6: With its bit set at address 0x3, a 0-to-1 change of a request's selected level sets its flag at the clock edge after evt_o changes.
- R7: A bit at address 0x4 enables falling edges. Setting both enables catches either edge. An edge with its enable clear sets no flag.
- R8: Flags at address 0x7 are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R9: If an edge sets a flag in the same cycle that a write clears it, the flag stays set.
- R10: irq_even_o is high when any even-numbered request has both its flag and its enable bit (address 0x5) set and bit 0 at address 0x6 is 1. irq_odd_o does the same for odd-numbered requests. The parity is that of the request number, not of the pin number.
- R11: Reads at addresses 0x0 to 0x6 return the values last written, with unused bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PORTS*16 | Asynchronous pin levels, port k in bits [16k+15:16k] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_even_o | output | 1 | Interrupt for even-numbered requests |
| irq_odd_o | output | 1 | Interrupt for odd-numbered requests |
| evt_o | output | 16 | Synchronized selected level per request |

## Verification
A wrong select register shows at once on evt_o, two edges after a pin moves. The wrong pin or port is followed, or the right one is ignored. A faulty previous-level register or edge decode shows one edge later as a missing or unexpected flag in the read-back of address 0x7. Errors in flag retention, in the clear priority or in the parity merge appear on the interrupt lines in the same cycle as the flag state that causes them. The bench therefore samples each output at the exact edge count where it must change, and also one edge earlier.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int unsigned NREQ      = 16;
  localparam int unsigned PORT_PINS = 16;
  localparam int unsigned GRP       = 4;
  localparam int unsigned PSEL_W    = 4;
  localparam int unsigned GSEL_W    = 2;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] ADR_PSEL_LO = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_PSEL_HI = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_GSEL    = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_RISE    = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_FALL    = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_IEN     = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 4'h6;
  localparam logic [ADDR_W-1:0] ADR_FLAG    = 4'h7;

  function automatic logic [NREQ-1:0] even_mask();
    logic [NREQ-1:0] m;
    for (int i = 0; i < int'(NREQ); i++) m[i] = (i % 2 == 0);
    return m;
  endfunction
endpackage

// File: rtl/extint_rstsync.sv
module extint_rstsync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_no = stage_q[1];
endmodule

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] safe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      safe_q <= '0;
    end else begin
      meta_q <= d_i;
      safe_q <= meta_q;
    end
  end

  assign q_o = safe_q;
endmodule

// File: rtl/extint_route.sv
module extint_route
  import extint_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS*PORT_PINS-1:0] pins_i,
  input  logic [NREQ*PSEL_W-1:0]         psel_i,
  input  logic [NREQ*GSEL_W-1:0]         gsel_i,
  output logic [NREQ-1:0]                lvl_o
);
  for (genvar r = 0; r < int'(NREQ); r++) begin : g_req
    localparam logic [3:0] GBASE = 4'((r / GRP) * GRP);
    logic [PSEL_W-1:0]    port_sel;
    logic [GSEL_W-1:0]    grp_sel;
    logic [3:0]           pin_idx;
    logic [PORT_PINS-1:0] word;
    logic                 sel_lvl;

    assign port_sel = psel_i[r*PSEL_W +: PSEL_W];
    assign grp_sel  = gsel_i[r*GSEL_W +: GSEL_W];
    assign pin_idx  = GBASE | {2'b00, grp_sel};

    always_comb begin
      word = '0;
      for (int p = 0; p < int'(NUM_PORTS); p++) begin
        if (port_sel == PSEL_W'(p)) word = pins_i[p*PORT_PINS +: PORT_PINS];
      end
      sel_lvl = word[pin_idx];
    end

    assign lvl_o[r] = sel_lvl;
  end
endmodule

// File: rtl/extint_edge.sv
module extint_edge
  import extint_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREQ-1:0] lvl_i,
  input  logic [NREQ-1:0] rise_en_i,
  input  logic [NREQ-1:0] fall_en_i,
  input  logic [NREQ-1:0] clr_i,
  output logic [NREQ-1:0] flag_o
);
  logic [NREQ-1:0] prev_q;
  logic [NREQ-1:0] flag_q;
  logic [NREQ-1:0] flag_d;
  logic [NREQ-1:0] hit;
  logic            flag_en;

  always_comb begin
    hit     = (rise_en_i & lvl_i & ~prev_q) | (fall_en_i & ~lvl_i & prev_q);
    flag_d  = (flag_q & ~clr_i) | hit;
    flag_en = |(hit | clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= lvl_i;
      if (flag_en) flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/extint_mapper.sv
module extint_mapper
  import extint_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_PORTS*PORT_PINS-1:0] pins_i,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic [ADDR_W-1:0]              rd_addr_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic                           irq_even_o,
  output logic                           irq_odd_o,
  output logic [NREQ-1:0]                evt_o
);
  localparam int unsigned NPIN    = NUM_PORTS * PORT_PINS;
  localparam int unsigned PSEL_TW = NREQ * PSEL_W;
  localparam int unsigned HALF_W  = PSEL_TW / 2;
  localparam logic [NREQ-1:0] EVEN_M = even_mask();

  logic                rst_n_sync;
  logic [NPIN-1:0]     pins_s;
  logic [PSEL_TW-1:0]  psel_q;
  logic [NREQ*GSEL_W-1:0] gsel_q;
  logic [NREQ-1:0]     rise_q, fall_q, ien_q;
  logic                sense_q;
  logic [NREQ-1:0]     lvl_w;
  logic [NREQ-1:0]     flag_w;
  logic [NREQ-1:0]     clr_w;
  logic                we_plo, we_phi, we_gsel, we_rise, we_fall, we_ien, we_ctrl;

  extint_rstsync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  extint_sync #(.WIDTH(NPIN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_sync),
    .d_i    (pins_i),
    .q_o    (pins_s)
  );

  extint_route #(.NUM_PORTS(NUM_PORTS)) u_route (
    .pins_i (pins_s),
    .psel_i (psel_q),
    .gsel_i (gsel_q),
    .lvl_o  (lvl_w)
  );

  extint_edge u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .lvl_i     (lvl_w),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .clr_i     (clr_w),
    .flag_o    (flag_w)
  );

  // Write decode: one clock enable per register.
  always_comb begin
    we_plo  = wr_en_i && (wr_addr_i == ADR_PSEL_LO);
    we_phi  = wr_en_i && (wr_addr_i == ADR_PSEL_HI);
    we_gsel = wr_en_i && (wr_addr_i == ADR_GSEL);
    we_rise = wr_en_i && (wr_addr_i == ADR_RISE);
    we_fall = wr_en_i && (wr_addr_i == ADR_FALL);
    we_ien  = wr_en_i && (wr_addr_i == ADR_IEN);
    we_ctrl = wr_en_i && (wr_addr_i == ADR_CTRL);
    clr_w   = (wr_en_i && (wr_addr_i == ADR_FLAG)) ? wr_data_i[NREQ-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      psel_q  <= '0;
      gsel_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      ien_q   <= '0;
      sense_q <= 1'b0;
    end else begin
      if (we_plo)  psel_q[HALF_W-1:0]       <= wr_data_i[HALF_W-1:0];
      if (we_phi)  psel_q[PSEL_TW-1:HALF_W] <= wr_data_i[HALF_W-1:0];
      if (we_gsel) gsel_q                   <= wr_data_i[NREQ*GSEL_W-1:0];
      if (we_rise) rise_q                   <= wr_data_i[NREQ-1:0];
      if (we_fall) fall_q                   <= wr_data_i[NREQ-1:0];
      if (we_ien)  ien_q                    <= wr_data_i[NREQ-1:0];
      if (we_ctrl) sense_q                  <= wr_data_i[0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      ADR_PSEL_LO: rd_data_o[HALF_W-1:0]      = psel_q[HALF_W-1:0];
      ADR_PSEL_HI: rd_data_o[HALF_W-1:0]      = psel_q[PSEL_TW-1:HALF_W];
      ADR_GSEL:    rd_data_o[NREQ*GSEL_W-1:0] = gsel_q;
      ADR_RISE:    rd_data_o[NREQ-1:0]        = rise_q;
      ADR_FALL:    rd_data_o[NREQ-1:0]        = fall_q;
      ADR_IEN:     rd_data_o[NREQ-1:0]        = ien_q;
      ADR_CTRL:    rd_data_o[0]               = sense_q;
      ADR_FLAG:    rd_data_o[NREQ-1:0]        = flag_w;
      default:     rd_data_o                  = '0;
    endcase
  end

  assign irq_even_o = sense_q & |(flag_w & ien_q & EVEN_M);
  assign irq_odd_o  = sense_q & |(flag_w & ien_q & ~EVEN_M);
  assign evt_o      = lvl_w;
endmodule

// File: rtl/extint_mapper_chk.sv
module extint_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [3:0]  wr_addr,
  input logic [31:0] wr_data,
  input logic [15:0] flag,
  input logic [15:0] rise,
  input logic [15:0] fall,
  input logic [15:0] ien,
  input logic        sense,
  input logic        irq_even,
  input logic        irq_odd
);
  logic [15:0] clr_seen;
  assign clr_seen = (wr_en && wr_addr == 4'h7) ? wr_data[15:0] : 16'h0;

  always @(posedge clk) begin
    if (!rst_n) assert_flags_reset_R1: assert (flag == 16'h0 && !irq_even && !irq_odd);
  end

  assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag & ~$past(flag) & ~($past(rise) | $past(fall))) == 16'h0));

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(flag) & ~$past(clr_seen) & ~flag) == 16'h0));

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sense |-> (!irq_even && !irq_odd));

  assert_odd_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_odd |-> |(flag & ien & 16'hAAAA));

  assert_even_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_even |-> |(flag & ien & 16'h5555));
endmodule

bind extint_mapper extint_mapper_chk u_chk (
  .clk      (clk_i),
  .rst_n    (rst_n_sync),
  .wr_en    (wr_en_i),
  .wr_addr  (wr_addr_i),
  .wr_data  (wr_data_i),
  .flag     (flag_w),
  .rise     (rise_q),
  .fall     (fall_q),
  .ien      (ien_q),
  .sense    (sense_q),
  .irq_even (irq_even_o),
  .irq_odd  (irq_odd_o)
);

// File: tb/sim_extint_mapper.sv
module sim_extint_mapper;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NP*16-1:0] pins;
  logic          wr_en;
  logic [3:0]    wr_addr;
  logic [31:0]   wr_data;
  logic [3:0]    rd_addr;
  logic [31:0]   rd_data;
  logic          irq_even, irq_odd;
  logic [15:0]   evt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  extint_mapper #(.NUM_PORTS(NP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .irq_even_o(irq_even), .irq_odd_o(irq_odd), .evt_o(evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic setpin(input int idx, input logic v);
    @(negedge clk);
    pins[idx] = v;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq_even", {31'b0, irq_even}, 32'h0);
    chk("R1 irq_odd", {31'b0, irq_odd}, 32'h0);
    chk("R1 evt", {16'b0, evt}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      chk($sformatf("R1 reg %0d", a), d, 32'h0);
    end
  endtask

  task automatic t_route;
    logic [31:0] d;
    // R3: default selects pin 0 of port 0 for requests 0-3
    setpin(0, 1'b1);
    waitn(2);
    chk("R3 default group", {28'b0, evt[3:0]}, 32'hF);
    setpin(0, 1'b0);
    waitn(2);
    // R2: request 5 -> port 2 ; R3: in-group select 3 -> pin 7
    wr(4'h0, 32'h0020_0000);
    wr(4'h2, 32'h0000_0C00);
    rd(4'h0, d); chk("R11 psel lo", d, 32'h0020_0000);
    rd(4'h2, d); chk("R11 gsel", d, 32'h0000_0C00);
    setpin(16 + 7, 1'b1);          // port 1 pin 7: not selected
    waitn(3);
    chk("R2 other port ignored", {31'b0, evt[5]}, 32'h0);
    setpin(2*16 + 7, 1'b1);
    waitn(1);
    chk("R5 evt not before two edges", {31'b0, evt[5]}, 32'h0);
    waitn(1);
    chk("R5 evt after two edges, ien clear", {31'b0, evt[5]}, 32'h1);
    wr(4'h0, 32'h0070_0000);       // port 7 is beyond NUM_PORTS
    chk("R2 out of range port gives 0", {31'b0, evt[5]}, 32'h0);
    wr(4'h0, 32'h0020_0000);
    chk("R2 port restored", {31'b0, evt[5]}, 32'h1);
    setpin(16 + 7, 1'b0);
    setpin(2*16 + 7, 1'b0);
    waitn(3);
  endtask

  task automatic t_shared;
    // R4: requests 8 and 9 both take port 3 pin 9
    wr(4'h1, 32'h0000_0033);
    wr(4'h2, 32'h0005_0C00);
    setpin(3*16 + 9, 1'b1);
    waitn(2);
    chk("R4 shared pin reqs 8,9", {28'b0, evt[11:8]}, 32'h3);
    setpin(3*16 + 9, 1'b0);
    waitn(3);
    chk("R4 shared pin low", {28'b0, evt[11:8]}, 32'h0);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(4'h3, 32'h20);
    setpin(2*16 + 7, 1'b1);
    waitn(2);
    rd(4'h7, d); chk("R6 flag not yet", d, 32'h0);
    waitn(1);
    rd(4'h7, d); chk("R6 rising flag", d, 32'h20);
    wr(4'h7, 32'h20);
    rd(4'h7, d); chk("R8 clear by one", d, 32'h0);
    setpin(2*16 + 7, 1'b0);
    waitn(4);
    rd(4'h7, d); chk("R7 fall ignored w/o enable", d, 32'h0);
    wr(4'h3, 32'h0);
    wr(4'h4, 32'h20);
    setpin(2*16 + 7, 1'b1);
    waitn(4);
    rd(4'h7, d); chk("R7 rise ignored w/o enable", d, 32'h0);
    setpin(2*16 + 7, 1'b0);
    waitn(4);
    rd(4'h7, d); chk("R7 falling flag", d, 32'h20);
    wr(4'h7, 32'h20);
    wr(4'h3, 32'h20);
    setpin(2*16 + 7, 1'b1);
    waitn(4);
    rd(4'h7, d); chk("R7 both: rise", d, 32'h20);
    wr(4'h7, 32'h20);
    setpin(2*16 + 7, 1'b0);
    waitn(4);
    rd(4'h7, d); chk("R7 both: fall", d, 32'h20);
    wr(4'h7, 32'h0);
    rd(4'h7, d); chk("R8 write zero keeps", d, 32'h20);
    wr(4'h7, 32'hFFDF);
    rd(4'h7, d); chk("R8 other bits keep", d, 32'h20);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(4'h5, 32'h20);
    chk("R10 no sense odd", {31'b0, irq_odd}, 32'h0);
    wr(4'h6, 32'h1);
    rd(4'h6, d); chk("R11 ctrl", d, 32'h1);
    chk("R10 odd req 5", {30'b0, irq_even, irq_odd}, 32'h1);
    wr(4'h5, 32'h0);
    chk("R10 ien clear", {30'b0, irq_even, irq_odd}, 32'h0);
    wr(4'h3, 32'h120);
    wr(4'h5, 32'h120);
    setpin(3*16 + 9, 1'b1);        // odd pin feeds request 8
    waitn(4);
    rd(4'h7, d); chk("R10 flags 5 and 8", d, 32'h120);
    chk("R10 both lines", {30'b0, irq_even, irq_odd}, 32'h3);
    wr(4'h7, 32'h20);
    chk("R10 even by request parity", {30'b0, irq_even, irq_odd}, 32'h2);
    wr(4'h7, 32'h100);
    chk("R10 lines low", {30'b0, irq_even, irq_odd}, 32'h0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(4'h4, 32'h120);
    setpin(3*16 + 9, 1'b0);
    waitn(1);
    wr(4'h7, 32'h100);             // clear lands on the set edge
    rd(4'h7, d); chk("R9 set wins over clear", d, 32'h100);
    wr(4'h7, 32'h100);
    rd(4'h7, d); chk("R9 later clear", d, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    waitn(3);
    rst_n = 1'b1;
    waitn(4);
    t_reset();
    t_route();
    t_shared();
    t_edges();
    t_irq();
    t_race();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule